// File: doc/BRIEF.md
# Dual-Pass Synchronous-Frame PI Current Regulator

This block computes the d-axis and q-axis voltage references of a motor current loop in signed fixed point. Each current-sampling interval has up to two computation passes. The first pass is triggered by a strobe. It runs a PI law on the error between the sampled current reference and the sampled measured current. It also adds a speed-times-flux decoupling term that cancels the back-EMF, so the plant looks like a plain R-L load.

A later strobe in the same interval starts the second pass. This pass runs the same proportional and integral gains on the change in current reference since the first pass. It scales that correction by a small selectable gain k and adds the result to the first-pass voltage. The second pass lets the voltage follow a moving reference within the interval.

One multiplier is shared in time between both axes and all terms. Gains, k and the output limit come from a small write-only register bank. A new value is applied only when the next first pass starts.

Top module: `dqpi_dual_pass`

## Requirements
- R1: After reset, `v_d` and `v_q` are 0, `v_valid` is low, Kp and Ki are 0, the limit is 2^(W-1)-1 and the k code is 0.
- R2: A first pass computes, per axis, u = (Kp·e + I + Ki·e + F) >>> FRAC, with e = ref − meas and I the stored integrator. F is −ω·λq on the d-axis and +ω·λd on the q-axis. The output is u clipped to ±limit.
- R3: Only a first pass may change the integrator, and it then stores I + Ki·e. A second pass leaves the integrator untouched.
- R4: A second pass outputs clip(v1 + k·((Kp·Δ + Ki·Δ) >>> FRAC)), where Δ = ref − (reference latched by the last first pass) and v1 is that axis's last first-pass output. k is 4 for code 0, 6 for code 1 and 8 for codes 2 and 3.
- R5: A second-pass strobe with `p2_inhibit` high is ignored. No `v_valid` pulse follows and the outputs keep the first-pass voltage.
- R6: Every output lies within ±limit. When an axis's first-pass u exceeds the limit, that axis's integrator keeps its previous value (anti-windup).
- R7: The register writes go to these addresses: 0 = Kp (signed), 1 = Ki (signed), 2 = limit (low W-1 bits, unsigned), 3 = k code (low 2 bits). A written value first applies at the next first pass, so a second pass still uses the values that were in force at the preceding first pass.
- R8: `v_valid` pulses for a single cycle and updates both axes together. The pulse comes 7 clock edges after the edge that accepts a first-pass strobe, and 5 edges after the edge that accepts a second-pass strobe.
- R9: Strobes that arrive while a pass is running are ignored. If both strobes come in the same idle cycle, the first pass runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | G | Register write data |
| p1_stb | input | 1 | Start a first pass |
| p2_stb | input | 1 | Start a second pass |
| p2_inhibit | input | 1 | Suppress the second pass on this strobe |
| meas_d | input | W | Sampled d-axis current |
| meas_q | input | W | Sampled q-axis current |
| ref_d | input | W | Sampled d-axis current reference |
| ref_q | input | W | Sampled q-axis current reference |
| omega_e | input | W | Electrical speed |
| flux_d | input | W | Estimated d-axis flux |
| flux_q | input | W | Estimated q-axis flux |
| v_d | output | W | d-axis voltage reference |
| v_q | output | W | q-axis voltage reference |
| v_valid | output | 1 | One-cycle pulse when both axes are written |

## Verification
A first-pass result is due 7 edges after the strobe is accepted, and a second-pass result 5 edges after. The bench drives each strobe on a falling edge and then counts falling edges until `v_valid` appears. It compares that count with the expected latency and reads both voltages only in that cycle. For an inhibited strobe, and for a strobe that lands on a busy block, the bench watches a full window longer than the first-pass latency. It checks that the number of pulses is zero or one, as expected, before it compares the held voltages.

// File: rtl/dqpi_pkg.sv
`timescale 1ns/1ps
package dqpi_pkg;
  typedef enum logic [1:0] {SQ_IDLE, SQ_RUN, SQ_FIN} sq_state_t;
  localparam logic [1:0] CFG_KP   = 2'd0;
  localparam logic [1:0] CFG_KI   = 2'd1;
  localparam logic [1:0] CFG_LIM  = 2'd2;
  localparam logic [1:0] CFG_KSEL = 2'd3;
endpackage

// File: rtl/dqpi_cfg.sv
`timescale 1ns/1ps
module dqpi_cfg #(
  parameter int W = 16,
  parameter int G = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [1:0]          addr,
  input  logic [G-1:0]        wdata,
  input  logic                load,
  output logic signed [G-1:0] kp,
  output logic signed [G-1:0] ki,
  output logic [W-2:0]        lim,
  output logic [1:0]          ksel
);
  import dqpi_pkg::*;
  logic signed [G-1:0] kp_s, ki_s;
  logic [W-2:0]        lim_s;
  logic [1:0]          ksel_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      kp_s <= '0; ki_s <= '0; lim_s <= '1; ksel_s <= '0;
    end else if (we) begin
      case (addr)
        CFG_KP:   kp_s   <= wdata;
        CFG_KI:   ki_s   <= wdata;
        CFG_LIM:  lim_s  <= wdata[W-2:0];
        default:  ksel_s <= wdata[1:0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kp <= '0; ki <= '0; lim <= '1; ksel <= '0;
    end else if (load) begin
      kp <= kp_s; ki <= ki_s; lim <= lim_s; ksel <= ksel_s;
    end
  end
endmodule

// File: rtl/dqpi_seq.sv
`timescale 1ns/1ps
module dqpi_seq #(
  parameter int N1  = 6,
  parameter int N2  = 4,
  parameter int STW = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           p1_stb,
  input  logic           p2_stb,
  input  logic           p2_inhibit,
  output logic           busy,
  output logic           mode,
  output logic [STW-1:0] step,
  output logic           mul_en,
  output logic           fin,
  output logic           take1,
  output logic           take2
);
  import dqpi_pkg::*;
  localparam logic [STW-1:0] LAST1 = STW'(N1 - 1);
  localparam logic [STW-1:0] LAST2 = STW'(N2 - 1);
  sq_state_t st;
  logic [STW-1:0] last;

  always_comb begin
    take1  = (st == SQ_IDLE) && p1_stb;
    take2  = (st == SQ_IDLE) && !p1_stb && p2_stb && !p2_inhibit;
    last   = mode ? LAST2 : LAST1;
    busy   = (st != SQ_IDLE);
    mul_en = (st == SQ_RUN);
    fin    = (st == SQ_FIN);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= SQ_IDLE; mode <= 1'b0; step <= '0;
    end else begin
      case (st)
        SQ_IDLE: begin
          step <= '0;
          if (take1)      begin st <= SQ_RUN; mode <= 1'b0; end
          else if (take2) begin st <= SQ_RUN; mode <= 1'b1; end
        end
        SQ_RUN: begin
          if (step == last) st <= SQ_FIN;
          else              step <= step + 1'b1;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dqpi_mul.sv
`timescale 1ns/1ps
module dqpi_mul #(
  parameter int AW = 16,
  parameter int BW = 17
) (
  input  logic signed [AW-1:0]    a,
  input  logic signed [BW-1:0]    b,
  output logic signed [AW+BW-1:0] p
);
  assign p = a * b;
endmodule

// File: rtl/dqpi_dual_pass.sv
`timescale 1ns/1ps
module dqpi_dual_pass #(
  parameter int W    = 16,
  parameter int G    = 16,
  parameter int FRAC = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic [1:0]          cfg_addr,
  input  logic [G-1:0]        cfg_wdata,
  input  logic                p1_stb,
  input  logic                p2_stb,
  input  logic                p2_inhibit,
  input  logic signed [W-1:0] meas_d,
  input  logic signed [W-1:0] meas_q,
  input  logic signed [W-1:0] ref_d,
  input  logic signed [W-1:0] ref_q,
  input  logic signed [W-1:0] omega_e,
  input  logic signed [W-1:0] flux_d,
  input  logic signed [W-1:0] flux_q,
  output logic signed [W-1:0] v_d,
  output logic signed [W-1:0] v_q,
  output logic                v_valid
);
  localparam int EW    = W + 1;
  localparam int PW    = G + EW;
  localparam int SW    = PW + 4;
  localparam int KW    = SW + 4;
  localparam int NSLOT = 6;
  localparam int STW   = $clog2(NSLOT);

  logic signed [G-1:0] kp_a, ki_a;
  logic [W-2:0]        lim_a;
  logic [1:0]          ksel_a;
  logic                busy, mode, mul_en, fin, take1, take2;
  logic [STW-1:0]      step;

  logic signed [EW-1:0] ea_d, ea_q;
  logic signed [W-1:0]  w_l, fl_d, fl_q, iref1_d, iref1_q, v1_d, v1_q;
  logic signed [SW-1:0] acc_d, acc_q;
  logic signed [PW-1:0] slot [0:NSLOT-1];
  logic signed [G-1:0]  mul_a;
  logic signed [EW-1:0] mul_b;
  logic signed [PW-1:0] prod;

  dqpi_cfg #(.W(W), .G(G)) cfg_i (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .load(take1), .kp(kp_a), .ki(ki_a), .lim(lim_a), .ksel(ksel_a));

  dqpi_seq #(.N1(6), .N2(4), .STW(STW)) seq_i (
    .clk(clk), .rst(rst), .p1_stb(p1_stb), .p2_stb(p2_stb),
    .p2_inhibit(p2_inhibit), .busy(busy), .mode(mode), .step(step),
    .mul_en(mul_en), .fin(fin), .take1(take1), .take2(take2));

  dqpi_mul #(.AW(G), .BW(EW)) mul_i (.a(mul_a), .b(mul_b), .p(prod));

  // operand capture at pass start
  always_ff @(posedge clk) begin
    if (rst) begin
      ea_d <= '0; ea_q <= '0; w_l <= '0; fl_d <= '0; fl_q <= '0;
      iref1_d <= '0; iref1_q <= '0;
    end else if (take1) begin
      ea_d <= EW'(ref_d) - EW'(meas_d);
      ea_q <= EW'(ref_q) - EW'(meas_q);
      w_l <= omega_e; fl_d <= flux_d; fl_q <= flux_q;
      iref1_d <= ref_d; iref1_q <= ref_q;
    end else if (take2) begin
      ea_d <= EW'(ref_d) - EW'(iref1_d);
      ea_q <= EW'(ref_q) - EW'(iref1_q);
    end
  end

  // operand schedule of the shared multiplier
  always_comb begin
    mul_a = '0;
    mul_b = '0;
    if (!mode) begin
      case (step)
        0: begin mul_a = kp_a;    mul_b = ea_d;      end
        1: begin mul_a = ki_a;    mul_b = ea_d;      end
        2: begin mul_a = G'(w_l); mul_b = EW'(fl_q); end
        3: begin mul_a = kp_a;    mul_b = ea_q;      end
        4: begin mul_a = ki_a;    mul_b = ea_q;      end
        5: begin mul_a = G'(w_l); mul_b = EW'(fl_d); end
        default: ;
      endcase
    end else begin
      case (step)
        0: begin mul_a = kp_a; mul_b = ea_d; end
        1: begin mul_a = ki_a; mul_b = ea_d; end
        2: begin mul_a = kp_a; mul_b = ea_q; end
        3: begin mul_a = ki_a; mul_b = ea_q; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (mul_en) slot[step] <= prod;
  end

  function automatic logic over(input logic signed [KW-1:0] x, input logic [W-2:0] l);
    logic signed [KW-1:0] ls;
    ls = KW'(l);
    return (x > ls) || (x < -ls);
  endfunction

  function automatic logic signed [W-1:0] clip(input logic signed [KW-1:0] x, input logic [W-2:0] l);
    logic signed [KW-1:0] ls;
    ls = KW'(l);
    if (x > ls)       return W'(ls);
    else if (x < -ls) return W'(-ls);
    else              return W'(x);
  endfunction

  logic signed [SW-1:0] cand_d, cand_q, u_d, u_q, corr_d, corr_q;
  logic signed [KW-1:0] kc_d, kc_q, t_d, t_q;

  always_comb begin
    cand_d = acc_d + SW'(slot[1]);
    cand_q = acc_q + SW'(slot[4]);
    u_d    = (SW'(slot[0]) + cand_d - SW'(slot[2])) >>> FRAC;
    u_q    = (SW'(slot[3]) + cand_q + SW'(slot[5])) >>> FRAC;
    corr_d = (SW'(slot[0]) + SW'(slot[1])) >>> FRAC;
    corr_q = (SW'(slot[2]) + SW'(slot[3])) >>> FRAC;
    case (ksel_a)
      2'd0: begin
        kc_d = KW'(corr_d) <<< 2;
        kc_q = KW'(corr_q) <<< 2;
      end
      2'd1: begin
        kc_d = (KW'(corr_d) <<< 2) + (KW'(corr_d) <<< 1);
        kc_q = (KW'(corr_q) <<< 2) + (KW'(corr_q) <<< 1);
      end
      default: begin
        kc_d = KW'(corr_d) <<< 3;
        kc_q = KW'(corr_q) <<< 3;
      end
    endcase
    t_d = KW'(v1_d) + kc_d;
    t_q = KW'(v1_q) + kc_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_d <= '0; v_q <= '0; v_valid <= 1'b0;
      v1_d <= '0; v1_q <= '0; acc_d <= '0; acc_q <= '0;
    end else begin
      v_valid <= fin;
      if (fin && !mode) begin
        v_d  <= clip(KW'(u_d), lim_a);
        v_q  <= clip(KW'(u_q), lim_a);
        v1_d <= clip(KW'(u_d), lim_a);
        v1_q <= clip(KW'(u_q), lim_a);
        if (!over(KW'(u_d), lim_a)) acc_d <= cand_d;
        if (!over(KW'(u_q), lim_a)) acc_q <= cand_q;
      end else if (fin) begin
        v_d <= clip(t_d, lim_a);
        v_q <= clip(t_q, lim_a);
      end
    end
  end
endmodule

// File: rtl/dqpi_chk.sv
`timescale 1ns/1ps
module dqpi_chk #(
  parameter int W  = 16,
  parameter int G  = 16,
  parameter int AW = 37
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 v_valid,
  input logic signed [W-1:0]  v_d,
  input logic signed [W-1:0]  v_q,
  input logic [W-2:0]         lim,
  input logic                 busy,
  input logic                 mode,
  input logic signed [AW-1:0] acc_d,
  input logic signed [AW-1:0] acc_q,
  input logic signed [G-1:0]  kp
);
  logic signed [W:0] lim_s, vd_s, vq_s;
  assign lim_s = {2'b00, lim};
  assign vd_s  = (W+1)'(v_d);
  assign vq_s  = (W+1)'(v_q);

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    v_valid |=> !v_valid);

  assert_within_limit_R6: assert property (@(posedge clk) disable iff (rst)
    v_valid |-> (vd_s <= lim_s) && (vd_s >= -lim_s) && (vq_s <= lim_s) && (vq_s >= -lim_s));

  assert_hold_between_results_R5: assert property (@(posedge clk) disable iff (rst)
    !v_valid |-> $stable(v_d) && $stable(v_q));

  assert_integrator_frozen_R3: assert property (@(posedge clk) disable iff (rst)
    (busy && mode) |=> $stable(acc_d) && $stable(acc_q));

  assert_gain_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(kp));
endmodule

bind dqpi_dual_pass dqpi_chk #(.W(W), .G(G), .AW(SW)) chk_i (
  .clk(clk), .rst(rst), .v_valid(v_valid), .v_d(v_d), .v_q(v_q),
  .lim(lim_a), .busy(busy), .mode(mode), .acc_d(acc_d), .acc_q(acc_q),
  .kp(kp_a));

// File: tb/dqpi_dual_pass_tb_top.sv
`timescale 1ns/1ps
module dqpi_dual_pass_tb_top;
  localparam int W = 16, G = 16, FRAC = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_we = 0; logic [1:0] cfg_addr = 0; logic [G-1:0] cfg_wdata = 0;
  logic p1_stb = 0, p2_stb = 0, p2_inhibit = 0;
  logic signed [W-1:0] meas_d = 0, meas_q = 0, ref_d = 0, ref_q = 0;
  logic signed [W-1:0] omega_e = 0, flux_d = 0, flux_q = 0;
  logic signed [W-1:0] v_d, v_q;
  logic v_valid;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dqpi_dual_pass #(.W(W), .G(G), .FRAC(FRAC)) dut_i (.*);

  // model state
  longint s_kp = 0, s_ki = 0, s_lim = 32767, s_ks = 0;
  longint a_kp = 0, a_ki = 0, a_lim = 32767, a_ks = 0;
  longint m_acc_d = 0, m_acc_q = 0, m_v1_d = 0, m_v1_q = 0, m_r1_d = 0, m_r1_q = 0;
  longint e_vd = 0, e_vq = 0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint clipv(input longint x, input longint l);
    if (x > l) return l;
    if (x < -l) return -l;
    return x;
  endfunction

  task automatic cfg(input logic [1:0] a, input longint d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = G'(d);
    @(negedge clk); cfg_we = 0;
    case (a)
      2'd0: s_kp = d;
      2'd1: s_ki = d;
      2'd2: s_lim = d;
      default: s_ks = d;
    endcase
  endtask

  task automatic model_p1();
    longint ed, eq, cd, cq, ud, uq;
    a_kp = s_kp; a_ki = s_ki; a_lim = s_lim; a_ks = s_ks;
    ed = longint'(ref_d) - longint'(meas_d);
    eq = longint'(ref_q) - longint'(meas_q);
    cd = m_acc_d + a_ki * ed;
    cq = m_acc_q + a_ki * eq;
    ud = (a_kp * ed + cd - longint'(omega_e) * longint'(flux_q)) >>> FRAC;
    uq = (a_kp * eq + cq + longint'(omega_e) * longint'(flux_d)) >>> FRAC;
    if (ud <= a_lim && ud >= -a_lim) m_acc_d = cd;
    if (uq <= a_lim && uq >= -a_lim) m_acc_q = cq;
    m_v1_d = clipv(ud, a_lim); m_v1_q = clipv(uq, a_lim);
    e_vd = m_v1_d; e_vq = m_v1_q;
    m_r1_d = ref_d; m_r1_q = ref_q;
  endtask

  task automatic model_p2();
    longint dd, dq, k;
    dd = longint'(ref_d) - m_r1_d;
    dq = longint'(ref_q) - m_r1_q;
    k = (a_ks == 0) ? 4 : (a_ks == 1) ? 6 : 8;
    e_vd = clipv(m_v1_d + k * ((a_kp * dd + a_ki * dd) >>> FRAC), a_lim);
    e_vq = clipv(m_v1_q + k * ((a_kp * dq + a_ki * dq) >>> FRAC), a_lim);
  endtask

  task automatic fire(input logic s1, input logic s2, input logic inh,
                      output int lat, output int np);
    @(negedge clk); p1_stb = s1; p2_stb = s2; p2_inhibit = inh;
    @(negedge clk); p1_stb = 0; p2_stb = 0; p2_inhibit = 0;
    lat = 0; np = 0;
    for (int c = 1; c <= 12; c++) begin
      @(negedge clk);
      if (v_valid) begin np++; if (lat == 0) lat = c; end
    end
  endtask

  task automatic set_in(input longint rd, input longint rq, input longint md, input longint mq,
                        input longint om, input longint fd, input longint fq);
    ref_d = W'(rd); ref_q = W'(rq); meas_d = W'(md); meas_q = W'(mq);
    omega_e = W'(om); flux_d = W'(fd); flux_q = W'(fq);
  endtask

  initial begin
    int lat, np;
    longint rl [5] = '{-300, -40, 0, 55, 400};
    longint ml [3] = '{-120, 0, 90};
    longint ol [3] = '{-50, 0, 70};
    int it;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1", "v_d after reset", v_d, 0);
    chk("R1", "v_q after reset", v_q, 0);
    chk("R1", "v_valid after reset", v_valid, 0);
    // R1: reset gains are zero -> pass1 output equals flux term only
    set_in(100, -80, 10, 20, 30, 40, 50);
    fire(1, 0, 0, lat, np); model_p1();
    chk("R1", "zero-gain d output", v_d, e_vd);
    chk("R1", "zero-gain q output", v_q, e_vq);

    cfg(2'd0, 512); cfg(2'd1, 64); cfg(2'd2, 1000);
    it = 0;
    foreach (rl[i]) foreach (ml[j]) foreach (ol[m]) begin
      cfg(2'd3, it % 4);
      set_in(rl[i], rl[(i + 2) % 5], ml[j], ml[(j + 1) % 3], ol[m], 150 - 40 * j, 200 - 60 * i);
      fire(1, 0, 0, lat, np); model_p1();
      chk("R8", "first-pass latency", lat, 7);
      chk("R8", "first-pass pulse count", np, 1);
      chk("R2", "first-pass v_d (R6 clip, R3 integ)", v_d, e_vd);
      chk("R2", "first-pass v_q (R6 clip, R3 integ)", v_q, e_vq);
      ref_d = W'(rl[i] + 37 * (j - 1)); ref_q = W'(rl[(i + 2) % 5] - 23 * m);
      if (it % 5 == 4) begin
        fire(0, 1, 1, lat, np);
        chk("R5", "inhibited pulse count", np, 0);
        chk("R5", "inhibited v_d held", v_d, e_vd);
        chk("R5", "inhibited v_q held", v_q, e_vq);
      end else begin
        fire(0, 1, 0, lat, np); model_p2();
        chk("R8", "second-pass latency", lat, 5);
        chk("R4", "second-pass v_d", v_d, e_vd);
        chk("R4", "second-pass v_q", v_q, e_vq);
      end
      it++;
    end

    // R6: large error drives saturation; integrator must hold
    set_in(3000, -3000, 0, 0, 0, 0, 0);
    fire(1, 0, 0, lat, np); model_p1();
    chk("R6", "saturated v_d", v_d, 1000);
    chk("R6", "saturated v_q", v_q, -1000);
    set_in(20, -20, 0, 0, 0, 0, 0);
    fire(1, 0, 0, lat, np); model_p1();
    chk("R6", "post-saturation v_d", v_d, e_vd);
    chk("R6", "post-saturation v_q", v_q, e_vq);

    // R7: writes between passes apply only at the next first pass
    set_in(200, 100, 150, 60, 10, 20, 30);
    fire(1, 0, 0, lat, np); model_p1();
    chk("R7", "base v_d", v_d, e_vd);
    cfg(2'd0, 1024); cfg(2'd3, 2);
    ref_d = 260; ref_q = 70;
    fire(0, 1, 0, lat, np); model_p2();
    chk("R7", "old gains on second pass v_d", v_d, e_vd);
    chk("R7", "old gains on second pass v_q", v_q, e_vq);
    fire(1, 0, 0, lat, np); model_p1();
    chk("R7", "new Kp on next first pass v_d", v_d, e_vd);
    chk("R7", "new Kp on next first pass v_q", v_q, e_vq);

    // R9: both strobes together -> first pass wins
    set_in(-90, 130, 40, -10, 60, -30, 25);
    fire(1, 1, 0, lat, np); model_p1();
    chk("R9", "simultaneous strobes latency", lat, 7);
    chk("R9", "simultaneous strobes v_d", v_d, e_vd);
    chk("R9", "simultaneous strobes v_q", v_q, e_vq);

    // R9: strobe while busy is ignored
    set_in(310, -150, 20, 30, 15, 80, -70);
    @(negedge clk); p1_stb = 1;
    @(negedge clk); p1_stb = 0;
    @(negedge clk);
    @(negedge clk); p1_stb = 1; ref_d = -500; ref_q = 500;
    @(negedge clk); p1_stb = 0;
    np = 0;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      if (v_valid) begin
        np++;
        if (np == 1) begin
          ref_d = 310; ref_q = -150; model_p1();
          chk("R9", "busy-strobe v_d uses first inputs", v_d, e_vd);
          chk("R9", "busy-strobe v_q uses first inputs", v_q, e_vq);
        end
      end
    end
    chk("R9", "busy-strobe pulse count", np, 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule